// File: doc/BRIEF.md
# Ratiometric Slope Resistance Measurement Sequencer

This block runs a single-slope resistance measurement around an external capacitor, an external comparator and two tri-state pins. It always runs the same four phases. First, the reference pin drives high to charge the capacitor for a programmed number of cycles. Next, the reference pin drives low, so the capacitor discharges through the reference resistor until the comparator reports that the capacitor voltage has dropped below a quarter of the supply. The reference pin then recharges the capacitor. Finally, the sensor pin drives low and the capacitor discharges through the sensor resistor until the comparator trips again. The two discharge times are the two counts the block reports. Software divides them to get the ratio of the sensor resistance to the reference resistance.

The comparator output is conditioned before use. It is forced to 0 while the comparator is switched off, and it is inverted back when the inputs are exchanged. It then goes through a synchronizer and an optional glitch filter, which accepts a new level only after that level has been held for a programmed number of consecutive samples. Each time is measured as the difference between two values of a free-running timer: the value when the discharge starts and the value when the filtered comparator output falls. A timeout aborts a phase that never sees a crossing. An edge-selectable interrupt flag tracks the filtered comparator output independently of the sequence.

Top module: `slope_meas_seq`

## Requirements
- R1: After reset, both pins are released (enable 0), and `busy`, `done`, `err`, `irq_flag` and `cmp_lvl` are all 0.
- R2: A phase drives a pin only as follows. The charge phase drives the reference pin high for exactly `chg_len` cycles. The reference discharge drives the reference pin low. The sensor discharge drives the sensor pin low while the reference pin is released. The two pin enables are never high together, and both are 0 while idle.
- R3: `ref_cnt` equals k + 2 + F. Here k is the number of clock edges from the edge that first drives the reference pin low to the first edge at which the comparator input is sampled low. F is `FILT_N` when the filter is enabled and 1 when it is bypassed.
- R4: `sns_cnt` obeys the same relation for the sensor discharge phase.
- R5: With the filter enabled, a comparator level that lasts fewer than `FILT_N` clock samples does not change `cmp_lvl`, and a level that lasts `FILT_N` samples does. With the filter bypassed, a single-sample level is accepted.
- R6: `irq_flag` is set by a rising edge of `cmp_lvl` when `edge_sel` is 0, and by a falling edge when `edge_sel` is 1. An edge of the other polarity does not set it.
- R7: `irq_flag` stays set until `flag_clr` is pulsed.
- R8: When `cmp_swap` is 1, the comparator input is inverted before use, so an exchanged comparator yields the same level and the same counts.
- R9: When `cmp_on` is 0, the conditioned comparator level is 0 whatever the comparator input, so a measurement cannot see a crossing.
- R10: If a discharge phase sees no falling edge within `tmo_len` cycles, the sequence aborts. It releases both pins, sets `err` and pulses `done`. A count equal to `tmo_len` is still accepted.
- R11: A `start` pulse is accepted only while idle. A `start` during a measurement has no effect, and the measurement produces one `done` pulse.
- R12: `done` is a one-cycle pulse, and both counts are valid while it is high. A new accepted `start` clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a measurement (pulse) |
| cmp_raw | input | 1 | Raw comparator output |
| cmp_on | input | 1 | Comparator enabled |
| cmp_swap | input | 1 | Comparator inputs exchanged; output is inverted |
| filt_en | input | 1 | Enable glitch filter |
| edge_sel | input | 1 | Flag edge: 0 rising, 1 falling |
| flag_clr | input | 1 | Clear interrupt flag |
| chg_len | input | CHG_W | Charge phase length in cycles |
| tmo_len | input | TMR_W | Discharge timeout in cycles |
| timer | input | TMR_W | Free-running timer |
| ref_oe | output | 1 | Reference pin drive enable |
| ref_out | output | 1 | Reference pin drive level |
| sns_oe | output | 1 | Sensor pin drive enable |
| sns_out | output | 1 | Sensor pin drive level |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Measurement finished (pulse) |
| err | output | 1 | Last measurement timed out |
| ref_cnt | output | TMR_W | Reference discharge count |
| sns_cnt | output | TMR_W | Sensor discharge count |
| cmp_lvl | output | 1 | Filtered comparator level |
| irq_flag | output | 1 | Comparator edge flag |

## Verification
The hardest case to reach from the ports is the timeout boundary. A crossing has to arrive on exactly the cycle the timeout would fire, and then again one cycle too late. The bench's behavioural RC model reaches this: it charges the capacitor to full supply before every discharge, so the crossing cycle is known in advance, and the bench sets `tmo_len` to the predicted count and then to one less. Glitches shorter than the filter window are produced by forcing the comparator level from the bench for a counted number of samples while the sequencer is idle.

// File: rtl/slope_pkg.sv
package slope_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CHG_REF = 3'd1,
        ST_DIS_REF = 3'd2,
        ST_CHG_SNS = 3'd3,
        ST_DIS_SNS = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic oe;
        logic out;
    } pin_drv_t;

    localparam pin_drv_t PIN_RELEASE = '{oe: 1'b0, out: 1'b0};
    localparam pin_drv_t PIN_HIGH    = '{oe: 1'b1, out: 1'b1};
    localparam pin_drv_t PIN_LOW     = '{oe: 1'b1, out: 1'b0};

endpackage

// File: rtl/slope_cmp_cond.sv
module slope_cmp_cond #(
    parameter int FILT_N      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_raw,
    input  logic cmp_on,
    input  logic cmp_swap,
    input  logic filt_en,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int FCW = (FILT_N < 2) ? 1 : $clog2(FILT_N);
    localparam logic [FCW-1:0] FLAST = FCW'(FILT_N - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [FCW-1:0]         cnt;
        logic                   lvl;
        logic                   prev;
    } cond_regs_t;

    cond_regs_t r_d, r_q;
    logic       cond;
    logic       samp;

    // gate when switched off, undo the inversion of an exchanged comparator
    assign cond = cmp_on & (cmp_raw ^ cmp_swap);
    assign samp = r_q.sync[SYNC_STAGES-1];

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[SYNC_STAGES-2:0], cond};
        r_d.prev = r_q.lvl;
        if (!filt_en) begin
            r_d.lvl = samp;
            r_d.cnt = '0;
        end else if (samp != r_q.lvl) begin
            if (r_q.cnt == FLAST) begin
                r_d.lvl = samp;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lvl  = r_q.lvl;
    assign rise = r_q.lvl & ~r_q.prev;
    assign fall = ~r_q.lvl & r_q.prev;

endmodule

// File: rtl/slope_irq_flag.sv
module slope_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic edge_sel,
    input  logic flag_clr,
    output logic flag
);
    logic flag_d, flag_q;
    logic set_ev;

    always_comb begin
        set_ev = edge_sel ? fall : rise;
        flag_d = flag_q;
        if (flag_clr) flag_d = 1'b0;
        if (set_ev)   flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

endmodule

// File: rtl/slope_seq_fsm.sv
module slope_seq_fsm
    import slope_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int CHG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CHG_W-1:0] chg_len,
    input  logic [TMR_W-1:0] tmo_len,
    input  logic [TMR_W-1:0] timer,
    input  logic             fall,
    output pin_drv_t         ref_pin,
    output pin_drv_t         sns_pin,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [TMR_W-1:0] ref_cnt,
    output logic [TMR_W-1:0] sns_cnt
);
    typedef struct packed {
        seq_state_e       state;
        logic [CHG_W-1:0] chg_cnt;
        logic [TMR_W-1:0] dis_cnt;
        logic [TMR_W-1:0] stamp;
        logic [TMR_W-1:0] ref_cnt;
        logic [TMR_W-1:0] sns_cnt;
        logic             done;
        logic             err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      chg_last;
    logic      dis_last;

    always_comb begin
        chg_last = ({1'b0, r_q.chg_cnt} + 1'b1) >= {1'b0, chg_len};
        dis_last = ({1'b0, r_q.dis_cnt} + 1'b1) >= {1'b0, tmo_len};
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state   = ST_CHG_REF;
                    r_d.chg_cnt = '0;
                    r_d.err     = 1'b0;
                end
            end
            ST_CHG_REF, ST_CHG_SNS: begin
                if (chg_last) begin
                    r_d.state   = (r_q.state == ST_CHG_REF) ? ST_DIS_REF : ST_DIS_SNS;
                    r_d.stamp   = timer;
                    r_d.dis_cnt = '0;
                end else begin
                    r_d.chg_cnt = r_q.chg_cnt + 1'b1;
                end
            end
            ST_DIS_REF, ST_DIS_SNS: begin
                if (fall) begin
                    if (r_q.state == ST_DIS_REF) begin
                        r_d.ref_cnt = timer - r_q.stamp;
                        r_d.state   = ST_CHG_SNS;
                        r_d.chg_cnt = '0;
                    end else begin
                        r_d.sns_cnt = timer - r_q.stamp;
                        r_d.state   = ST_IDLE;
                        r_d.done    = 1'b1;
                    end
                end else if (dis_last) begin
                    r_d.state = ST_IDLE;
                    r_d.err   = 1'b1;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.dis_cnt = r_q.dis_cnt + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ref_pin = PIN_RELEASE;
        sns_pin = PIN_RELEASE;
        unique case (r_q.state)
            ST_CHG_REF, ST_CHG_SNS: ref_pin = PIN_HIGH;
            ST_DIS_REF:             ref_pin = PIN_LOW;
            ST_DIS_SNS:             sns_pin = PIN_LOW;
            default: ;
        endcase
    end

    assign busy    = (r_q.state != ST_IDLE);
    assign done    = r_q.done;
    assign err     = r_q.err;
    assign ref_cnt = r_q.ref_cnt;
    assign sns_cnt = r_q.sns_cnt;

endmodule

// File: rtl/slope_meas_seq.sv
module slope_meas_seq
    import slope_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int CHG_W       = 12,
    parameter int FILT_N      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_raw,
    input  logic             cmp_on,
    input  logic             cmp_swap,
    input  logic             filt_en,
    input  logic             edge_sel,
    input  logic             flag_clr,
    input  logic [CHG_W-1:0] chg_len,
    input  logic [TMR_W-1:0] tmo_len,
    input  logic [TMR_W-1:0] timer,
    output logic             ref_oe,
    output logic             ref_out,
    output logic             sns_oe,
    output logic             sns_out,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [TMR_W-1:0] ref_cnt,
    output logic [TMR_W-1:0] sns_cnt,
    output logic             cmp_lvl,
    output logic             irq_flag
);
    logic     lvl_rise;
    logic     lvl_fall;
    pin_drv_t ref_pin;
    pin_drv_t sns_pin;

    slope_cmp_cond #(
        .FILT_N      (FILT_N),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_raw  (cmp_raw),
        .cmp_on   (cmp_on),
        .cmp_swap (cmp_swap),
        .filt_en  (filt_en),
        .lvl      (cmp_lvl),
        .rise     (lvl_rise),
        .fall     (lvl_fall)
    );

    slope_irq_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (lvl_rise),
        .fall     (lvl_fall),
        .edge_sel (edge_sel),
        .flag_clr (flag_clr),
        .flag     (irq_flag)
    );

    slope_seq_fsm #(
        .TMR_W (TMR_W),
        .CHG_W (CHG_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .chg_len (chg_len),
        .tmo_len (tmo_len),
        .timer   (timer),
        .fall    (lvl_fall),
        .ref_pin (ref_pin),
        .sns_pin (sns_pin),
        .busy    (busy),
        .done    (done),
        .err     (err),
        .ref_cnt (ref_cnt),
        .sns_cnt (sns_cnt)
    );

    assign ref_oe  = ref_pin.oe;
    assign ref_out = ref_pin.out;
    assign sns_oe  = sns_pin.oe;
    assign sns_out = sns_pin.out;

endmodule

// File: rtl/slope_meas_seq_chk.sv
module slope_meas_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic err,
    input logic ref_oe,
    input logic sns_oe,
    input logic irq_flag,
    input logic flag_clr
);
    // R2
    pin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_oe && sns_oe));

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ref_oe && !sns_oe));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    // R11
    start_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

endmodule

bind slope_meas_seq slope_meas_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .ref_oe   (ref_oe),
    .sns_oe   (sns_oe),
    .irq_flag (irq_flag),
    .flag_clr (flag_clr)
);

// File: tb/slope_meas_seq_tb.sv
module slope_meas_seq_tb;
    localparam int TMR_W  = 16;
    localparam int CHG_W  = 12;
    localparam int FILT_N = 4;
    localparam int VDD    = 65536;
    localparam int VREF   = VDD / 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             cmp_raw;
    logic             cmp_on = 1'b1;
    logic             cmp_swap = 1'b0;
    logic             filt_en = 1'b0;
    logic             edge_sel = 1'b0;
    logic             flag_clr = 1'b0;
    logic [CHG_W-1:0] chg_len = 12'd200;
    logic [TMR_W-1:0] tmo_len = 16'd4000;
    logic [TMR_W-1:0] timer = '0;
    logic             ref_oe, ref_out, sns_oe, sns_out;
    logic             busy, done, err, cmp_lvl, irq_flag;
    logic [TMR_W-1:0] ref_cnt, sns_cnt;

    int  vcap = 0;
    int  a_ref = 50;
    int  a_sns = 80;
    logic force_en = 1'b0;
    logic force_val = 1'b0;
    int  done_seen = 0;
    int  cap_ref, cap_sns, cap_err;
    int  run = 0, last_run = 0, both_drv = 0;
    int  checks = 0, errors = 0;

    always #5 clk = ~clk;

    slope_meas_seq #(.TMR_W(TMR_W), .CHG_W(CHG_W), .FILT_N(FILT_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_raw(cmp_raw),
        .cmp_on(cmp_on), .cmp_swap(cmp_swap), .filt_en(filt_en),
        .edge_sel(edge_sel), .flag_clr(flag_clr), .chg_len(chg_len),
        .tmo_len(tmo_len), .timer(timer), .ref_oe(ref_oe), .ref_out(ref_out),
        .sns_oe(sns_oe), .sns_out(sns_out), .busy(busy), .done(done),
        .err(err), .ref_cnt(ref_cnt), .sns_cnt(sns_cnt), .cmp_lvl(cmp_lvl),
        .irq_flag(irq_flag)
    );

    function automatic int chg_step(int v);
        int nv;
        nv = v + ((VDD - v) * 100) / 1024 + 1;
        return (nv > VDD) ? VDD : nv;
    endfunction

    function automatic int dis_step(int v, int a);
        int nv;
        nv = v - (v * a) / 1024 - 1;
        return (nv < 0) ? 0 : nv;
    endfunction

    // expected count from a full charge: crossing steps + sync + filter
    function automatic int exp_count(int a, logic fen);
        int v = VDD;
        int d = 0;
        while (v > VREF) begin
            v = dis_step(v, a);
            d++;
        end
        return d + 2 + (fen ? FILT_N : 1);
    endfunction

    // comparator: true when cap above ref; an exchanged comparator inverts
    assign cmp_raw = cmp_swap ^ (force_en ? force_val : (vcap > VREF));

    // RC model and monitor, updated away from the active edge
    always @(negedge clk) begin
        timer <= timer + 1'b1;
        if (ref_oe && ref_out)      vcap = chg_step(vcap);
        else if (ref_oe && !ref_out) vcap = dis_step(vcap, a_ref);
        else if (sns_oe && !sns_out) vcap = dis_step(vcap, a_sns);
        if (ref_oe && sns_oe) both_drv++;
        if (ref_oe && ref_out) run++;
        else if (run != 0) begin
            last_run = run;
            run = 0;
        end
        if (done) begin
            done_seen++;
            cap_ref = int'(ref_cnt);
            cap_sns = int'(sns_cnt);
            cap_err = int'(err);
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_meas(int ar, int as, int cl, logic fen, int tmo, bit mid_start);
        a_ref = ar;
        a_sns = as;
        chg_len = CHG_W'(cl);
        filt_en = fen;
        tmo_len = TMR_W'(tmo);
        done_seen = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (mid_start) begin
            cyc(30);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        for (int i = 0; i < 20000 && done_seen == 0; i++) @(negedge clk);
        cyc(5);
    endtask

    task automatic meas_ok(int ar, int as, int cl, logic fen, bit mid_start, string tag);
        int er, es;
        er = exp_count(ar, fen);
        es = exp_count(as, fen);
        run_meas(ar, as, cl, fen, 4000, mid_start);
        chk(done_seen == 1, "R12", {tag, " done pulses"}, done_seen, 1);
        chk(cap_ref == er, "R3", {tag, " ref_cnt"}, cap_ref, er);
        chk(cap_sns == es, "R4", {tag, " sns_cnt"}, cap_sns, es);
        chk(cap_err == 0, "R12", {tag, " err"}, cap_err, 0);
        chk(last_run == cl, "R2", {tag, " charge length"}, last_run, cl);
    endtask

    initial begin
        #(150000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int m;
        void'($urandom(32'h5EED));
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk(!ref_oe && !sns_oe, "R1", "pins released", int'(ref_oe) + int'(sns_oe), 0);
        chk(!busy && !done && !err, "R1", "busy/done/err", int'(busy) + int'(done) + int'(err), 0);
        chk(!irq_flag && !cmp_lvl, "R1", "flag/level", int'(irq_flag) + int'(cmp_lvl), 0);

        // directed first run with a start pulse during the measurement (R11)
        meas_ok(60, 90, 180, 1'b1, 1'b1, "R11 mid-start");

        // random measurements
        for (int i = 0; i < 8; i++) begin
            meas_ok(int'($urandom_range(120, 20)), int'($urandom_range(120, 20)),
                    int'($urandom_range(250, 150)), logic'($urandom_range(1, 0)), 1'b0, "random");
        end

        // R8 exchanged comparator gives the same counts
        cmp_swap = 1'b1;
        meas_ok(45, 110, 160, 1'b1, 1'b0, "R8 swapped");
        force_en = 1'b1;
        force_val = 1'b1;
        cyc(12);
        chk(cmp_lvl == 1'b1, "R8", "swapped level", int'(cmp_lvl), 1);
        force_en = 1'b0;
        cmp_swap = 1'b0;
        cyc(12);

        // R10 timeout boundary: count equal to the limit is accepted
        m = exp_count(40, 1'b1);
        run_meas(40, 100, 200, 1'b1, m, 1'b0);
        chk(cap_err == 0, "R10", "count at limit err", cap_err, 0);
        chk(cap_ref == m, "R10", "count at limit ref_cnt", cap_ref, m);
        run_meas(40, 100, 200, 1'b1, m - 1, 1'b0);
        chk(done_seen == 1, "R10", "timeout done", done_seen, 1);
        chk(cap_err == 1, "R10", "timeout err", cap_err, 1);
        chk(!ref_oe && !sns_oe && !busy, "R10", "released after abort",
            int'(ref_oe) + int'(sns_oe) + int'(busy), 0);
        // R12 err cleared by the next start
        meas_ok(70, 70, 170, 1'b0, 1'b0, "R12 after error");

        // R9 comparator off
        cmp_on = 1'b0;
        run_meas(50, 50, 160, 1'b0, 300, 1'b0);
        chk(cap_err == 1, "R9", "off measurement err", cap_err, 1);
        force_en = 1'b1;
        force_val = 1'b1;
        cyc(12);
        chk(cmp_lvl == 1'b0, "R9", "off level", int'(cmp_lvl), 0);
        cmp_on = 1'b1;
        cyc(12);
        chk(cmp_lvl == 1'b1, "R9", "on level", int'(cmp_lvl), 1);

        // R5 / R6 / R7 glitch filter and flag, sequencer idle
        filt_en = 1'b1;
        edge_sel = 1'b1;
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        force_val = 1'b0;
        cyc(FILT_N - 1);
        force_val = 1'b1;
        cyc(12);
        chk(cmp_lvl == 1'b1, "R5", "short glitch level", int'(cmp_lvl), 1);
        chk(irq_flag == 1'b0, "R5", "short glitch flag", int'(irq_flag), 0);
        force_val = 1'b0;
        cyc(FILT_N);
        force_val = 1'b1;
        cyc(2);
        chk(cmp_lvl == 1'b0, "R5", "full-length low level", int'(cmp_lvl), 0);
        cyc(12);
        chk(irq_flag == 1'b1, "R6", "falling edge sets flag", int'(irq_flag), 1);
        cyc(20);
        chk(irq_flag == 1'b1, "R7", "flag held", int'(irq_flag), 1);
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        cyc(2);
        chk(irq_flag == 1'b0, "R7", "flag cleared", int'(irq_flag), 0);
        // rising edge with falling selected
        force_val = 1'b0;
        cyc(12);
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        force_val = 1'b1;
        cyc(12);
        chk(irq_flag == 1'b0, "R6", "rise ignored when falling selected", int'(irq_flag), 0);
        // rising edge selected
        edge_sel = 1'b0;
        force_val = 1'b0;
        cyc(12);
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        force_val = 1'b1;
        cyc(12);
        chk(irq_flag == 1'b1, "R6", "rising edge sets flag", int'(irq_flag), 1);
        // bypassed filter passes a one-sample glitch
        filt_en = 1'b0;
        edge_sel = 1'b1;
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        force_val = 1'b0;
        cyc(1);
        force_val = 1'b1;
        cyc(12);
        chk(irq_flag == 1'b1, "R5", "bypass glitch accepted", int'(irq_flag), 1);
        force_en = 1'b0;

        chk(both_drv == 0, "R2", "both pins driven cycles", both_drv, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule